// File: doc/BRIEF.md
# Interrupt Source Command/Status Unit

This unit holds the interrupt bookkeeping for a peripheral with five interrupt sources: two parallel ports and three counter/timers. Each source owns a command/status byte with four flags: pending, under service, enabled and error. A host changes these flags only by writing a 3-bit command code into the top of that byte. Reading the byte returns the flags. Hardware inside the peripheral marks a source pending with a one-cycle event pulse.

A master control byte gates all requests, can suppress the vector during acknowledge, and can cut the daisy chain below this device. It also carries three "vector carries status" bits and a self-clearing software reset. The unit raises a request for the highest-priority eligible source. It answers an acknowledge from the host by marking that source under service and presenting its vector for one cycle. It drives an enable-out signal for lower-priority devices on the chain.

The acknowledge path is a two-state machine:
- ACK_IDLE waits. It takes the transition "accept" to ACK_GRANT when the acknowledge is asserted, the chain enable-in is high and a request is active. In that same cycle the winner's under-service flag is set.
- ACK_GRANT presents the vector. It always takes the transition "release" back to ACK_IDLE on the next clock.

Top module: `irq_cmd_stat_unit`

## Requirements
- R1: After rst_n the four flags of every source and all master bits are zero. int_req is low, ieo equals iei, and address 0x1F reads 0xFF.
- R2: A write to address 0x08+i (source i, 0 to 4) applies the command in bits 7:5. The codes are: 0 none; 1 clear pending and under-service; 2 set under-service; 3 clear under-service; 4 set pending; 5 clear pending; 6 set enable; 7 clear enable. Bits 4:0 of the write are ignored, and code 0 changes nothing.
- R3: Reading 0x08+i returns under-service in bit 7, enable in bit 6, pending in bit 5 and error in bit 4, with bits 3:0 zero. Vector register i sits at 0x10+i and reads back what was written.
- R4: int_req is high only when some source has pending=1, enable=1 and under-service=0, master enable (bit 7 of address 0x00) is 1, and no source of equal or higher priority is under service.
- R5: A hardware event on a source that is already pending sets its error flag. Clearing pending with code 1 or 5 clears error as well.
- R6: Priority is fixed, with source 0 the highest and source 4 the lowest. A source under service blocks requests from itself and from every lower-priority source, but not from higher-priority ones.
- R7: Address 0x1F returns the vector of the current winning requester, or 0xFF when there is none.
- R8: ieo = iei AND NOT disable-lower-chain (master bit 6) AND no source under service AND no request active.
- R9: An accepted acknowledge sets under-service on the winner in the same edge. On the following cycle vec_valid is high for exactly one cycle, carrying the winner's vector. If that source's status-in-vector bit is set, vector bits 3:1 are replaced by the source index. The bits are: master bit 4 for source 0, bit 3 for source 1, bit 2 for sources 2 to 4.
- R10: With no-vector (master bit 5) set, an acknowledge still sets under-service, but vec_valid stays low. vec_out is zero whenever vec_valid is low.
- R11: An acknowledge while iei is low, or while no request is active, changes no flag.
- R12: Writing master bit 0 as 1 clears every source's flags and all master bits. The vector registers keep their values, and bit 0 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 6 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 6 | Host read address |
| rd_data | output | 8 | Read data (combinational) |
| src_evt | input | 5 | Per-source hardware pending event |
| iack | input | 1 | Interrupt acknowledge from host |
| iei | input | 1 | Daisy-chain enable in |
| int_req | output | 1 | Interrupt request |
| ieo | output | 1 | Daisy-chain enable out |
| vec_valid | output | 1 | Vector presented this cycle |
| vec_out | output | 8 | Acknowledge vector |

## Verification
The hardest condition to reach is nested service: a low-priority source is under service while a blocked lower source and an unblocked higher source both become pending. The stimulus gets there by acknowledging a counter/timer first. It then raises events on the lowest source, checking that the request stays low. Finally it raises an event on a port source and checks that the request returns and that the current-vector register names the port. Acknowledges are issued with the chain input low and with the no-vector bit set, so that the grant path is seen both when it is refused and when it completes silently.

// File: rtl/irq_cs_pkg.sv
package irq_cs_pkg;

    typedef enum logic [2:0] {
        CMD_NULL         = 3'd0,
        CMD_CLR_PEND_SVC = 3'd1,
        CMD_SET_SVC      = 3'd2,
        CMD_CLR_SVC      = 3'd3,
        CMD_SET_PEND     = 3'd4,
        CMD_CLR_PEND     = 3'd5,
        CMD_SET_EN       = 3'd6,
        CMD_CLR_EN       = 3'd7
    } irq_cmd_e;

    typedef enum logic [0:0] {
        ACK_IDLE  = 1'b0,
        ACK_GRANT = 1'b1
    } ack_state_e;

    typedef struct packed {
        logic svc;
        logic en;
        logic pend;
        logic err;
    } src_flags_t;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_clr,
    input  logic       cmd_we,
    input  irq_cmd_e   cmd,
    input  logic       hw_evt,
    input  logic       ack_hit,
    output src_flags_t flags
);

    src_flags_t flags_d;
    logic       clearing_pend;

    assign clearing_pend = cmd_we && (cmd == CMD_CLR_PEND_SVC || cmd == CMD_CLR_PEND);

    always_comb begin
        flags_d = flags;
        if (cmd_we) begin
            case (cmd)
                CMD_CLR_PEND_SVC: begin
                    flags_d.pend = 1'b0;
                    flags_d.svc  = 1'b0;
                    flags_d.err  = 1'b0;
                end
                CMD_SET_SVC:  flags_d.svc = 1'b1;
                CMD_CLR_SVC:  flags_d.svc = 1'b0;
                CMD_SET_PEND: flags_d.pend = 1'b1;
                CMD_CLR_PEND: begin
                    flags_d.pend = 1'b0;
                    flags_d.err  = 1'b0;
                end
                CMD_SET_EN:   flags_d.en = 1'b1;
                CMD_CLR_EN:   flags_d.en = 1'b0;
                default:      flags_d = flags;
            endcase
        end
        if (hw_evt) begin
            if (flags.pend && !clearing_pend) begin
                flags_d.err = 1'b1;
            end
            flags_d.pend = 1'b1;
        end
        if (ack_hit) begin
            flags_d.svc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (soft_clr) begin
            flags <= '0;
        end else begin
            flags <= flags_d;
        end
    end

    AST_ERR_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        flags.err |-> flags.pend); // R5

    AST_CLR_EN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd == CMD_CLR_EN && !soft_clr) |=> !flags.en); // R2

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int NSRC  = 5,
    parameter int IDX_W = 3
) (
    input  logic             mie,
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  en,
    input  logic [NSRC-1:0]  svc,
    output logic [NSRC-1:0]  win_oh,
    output logic             any_req,
    output logic             any_svc,
    output logic [IDX_W-1:0] win_idx
);

    logic [NSRC-1:0] blk;
    logic [NSRC-1:0] seen;
    logic [NSRC-1:0] req;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        if (i == 0) begin : g_top
            assign blk[i]  = svc[i];
            assign seen[i] = 1'b0;
        end else begin : g_rest
            assign blk[i]  = blk[i-1] | svc[i];
            assign seen[i] = seen[i-1] | req[i-1];
        end
        assign req[i]    = mie & pend[i] & en[i] & ~blk[i];
        assign win_oh[i] = req[i] & ~seen[i];
    end

    assign any_req = |req;
    assign any_svc = |svc;

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (win_oh[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_cs_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             iack,
    input  logic             iei,
    input  logic             any_req,
    input  logic [IDX_W-1:0] win_idx,
    output logic             ack_fire,
    output logic             grant,
    output logic [IDX_W-1:0] grant_idx
);

    ack_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ACK_IDLE;
            grant_idx <= '0;
        end else begin
            state_q <= state_d;
            if (ack_fire) begin
                grant_idx <= win_idx;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: begin
                if (iack && iei && any_req && !soft_clr) begin
                    state_d = ACK_GRANT;
                end
            end
            ACK_GRANT: state_d = ACK_IDLE;
        endcase
    end

    always_comb begin
        ack_fire = 1'b0;
        grant    = 1'b0;
        unique case (state_q)
            ACK_IDLE:  ack_fire = iack && iei && any_req && !soft_clr;
            ACK_GRANT: grant    = 1'b1;
        endcase
    end

    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_GRANT) |=> (state_q == ACK_IDLE)); // R9

endmodule

// File: rtl/irq_cmd_stat_unit.sv
module irq_cmd_stat_unit
    import irq_cs_pkg::*;
#(
    parameter int NSRC      = 5,
    parameter int AW        = 6,
    parameter int MSTR_ADDR = 'h00,
    parameter int STAT_BASE = 'h08,
    parameter int VEC_BASE  = 'h10,
    parameter int CURV_ADDR = 'h1F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    input  logic [NSRC-1:0] src_evt,
    input  logic            iack,
    input  logic            iei,
    output logic            int_req,
    output logic            ieo,
    output logic            vec_valid,
    output logic [7:0]      vec_out
);

    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [AW-1:0] MSTR_A = AW'(MSTR_ADDR);
    localparam logic [AW-1:0] CURV_A = AW'(CURV_ADDR);

    // master fields
    logic       mie_q, dlc_q, nv_q;
    logic [2:0] vis_q;
    logic       soft_clr;
    logic [7:0] vec_q [NSRC];

    src_flags_t      flags [NSRC];
    logic [NSRC-1:0] cmd_we, ack_hit, pend_v, en_v, svc_v, win_oh;
    logic            any_req, any_svc, ack_fire, grant;
    logic [IDX_W-1:0] win_idx, grant_idx;
    logic [7:0]      win_raw, grant_raw, cur_vec, grant_vec;

    assign soft_clr = wr_en && (wr_addr == MSTR_A) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mie_q <= 1'b0;
            dlc_q <= 1'b0;
            nv_q  <= 1'b0;
            vis_q <= '0;
            for (int i = 0; i < NSRC; i++) begin
                vec_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr == MSTR_A) begin
                if (wr_data[0]) begin
                    mie_q <= 1'b0;
                    dlc_q <= 1'b0;
                    nv_q  <= 1'b0;
                    vis_q <= '0;
                end else begin
                    mie_q <= wr_data[7];
                    dlc_q <= wr_data[6];
                    nv_q  <= wr_data[5];
                    vis_q <= wr_data[4:2];
                end
            end
            for (int i = 0; i < NSRC; i++) begin
                if (wr_addr == AW'(VEC_BASE + i)) begin
                    vec_q[i] <= wr_data;
                end
            end
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [AW-1:0] SA = AW'(STAT_BASE + i);
        assign cmd_we[i]  = wr_en && (wr_addr == SA);
        assign ack_hit[i] = ack_fire && win_oh[i];

        irq_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .cmd_we   (cmd_we[i]),
            .cmd      (irq_cmd_e'(wr_data[7:5])),
            .hw_evt   (src_evt[i]),
            .ack_hit  (ack_hit[i]),
            .flags    (flags[i])
        );

        assign pend_v[i] = flags[i].pend;
        assign en_v[i]   = flags[i].en;
        assign svc_v[i]  = flags[i].svc;
    end

    irq_prio_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .mie     (mie_q),
        .pend    (pend_v),
        .en      (en_v),
        .svc     (svc_v),
        .win_oh  (win_oh),
        .any_req (any_req),
        .any_svc (any_svc),
        .win_idx (win_idx)
    );

    irq_ack_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .iack      (iack),
        .iei       (iei),
        .any_req   (any_req),
        .win_idx   (win_idx),
        .ack_fire  (ack_fire),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    function automatic logic [7:0] merge_vec(input logic [7:0] v,
                                             input logic [IDX_W-1:0] idx,
                                             input logic [2:0] vis);
        logic use_st;
        if (idx == IDX_W'(0))      use_st = vis[2];
        else if (idx == IDX_W'(1)) use_st = vis[1];
        else                       use_st = vis[0];
        return use_st ? {v[7:4], 3'(idx), v[0]} : v;
    endfunction

    always_comb begin
        win_raw   = '0;
        grant_raw = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (win_idx == IDX_W'(i))   win_raw   = vec_q[i];
            if (grant_idx == IDX_W'(i)) grant_raw = vec_q[i];
        end
    end

    assign cur_vec   = any_req ? merge_vec(win_raw, win_idx, vis_q) : 8'hFF;
    assign grant_vec = merge_vec(grant_raw, grant_idx, vis_q);

    assign int_req   = any_req;
    assign ieo       = iei && !dlc_q && !any_svc && !any_req;
    assign vec_valid = grant && !nv_q;
    assign vec_out   = vec_valid ? grant_vec : 8'h00;

    always_comb begin
        rd_data = '0;
        if (rd_addr == MSTR_A) rd_data = {mie_q, dlc_q, nv_q, vis_q, 2'b00};
        if (rd_addr == CURV_A) rd_data = cur_vec;
        for (int i = 0; i < NSRC; i++) begin
            if (rd_addr == AW'(STAT_BASE + i))
                rd_data = {flags[i].svc, flags[i].en, flags[i].pend, flags[i].err, 4'b0000};
            if (rd_addr == AW'(VEC_BASE + i))
                rd_data = vec_q[i];
        end
    end

    AST_REQ_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> mie_q); // R4

    AST_IEO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ieo |-> (iei && !dlc_q)); // R8

    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == 8'h00)); // R10

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh)); // R6

    AST_ACK_MARKS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (svc_v != '0)); // R9

endmodule

// File: tb/sim_irq_cmd_stat_unit.sv
`timescale 1ns/1ps
module sim_irq_cmd_stat_unit;

    localparam int SEL_RD  = 0;
    localparam int SEL_REQ = 1;
    localparam int SEL_IEO = 2;
    localparam int SEL_VEC = 3;

    typedef struct {
        int         sel;
        logic [8:0] exp;
        string      tag;
    } item_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] src_evt = '0;
    logic       iack = 0;
    logic       iei = 1;
    logic       int_req, ieo, vec_valid;
    logic [7:0] vec_out;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    irq_cmd_stat_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .src_evt(src_evt), .iack(iack), .iei(iei),
        .int_req(int_req), .ieo(ieo), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    function automatic logic [8:0] sample(int sel);
        case (sel)
            SEL_RD:  return {1'b0, rd_data};
            SEL_REQ: return {8'b0, int_req};
            SEL_IEO: return {8'b0, ieo};
            default: return {vec_valid, vec_out};
        endcase
    endfunction

    // monitor: compares queued expectations one time unit after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [8:0] act;
                it  = sb_q.pop_front();
                act = sample(it.sel);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_now(int sel, logic [8:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_rd(logic [5:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        rd_addr = a;
        push_now(SEL_RD, {1'b0, exp}, tag);
    endtask

    task automatic chk_sig(int sel, logic exp, string tag);
        @(negedge clk);
        push_now(sel, {8'b0, exp}, tag);
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 0;
    endtask

    task automatic evt(logic [4:0] m);
        @(negedge clk);
        src_evt = m;
        @(posedge clk);
        #1 src_evt = '0;
    endtask

    task automatic ack(logic [8:0] exp_vec, string tag);
        @(negedge clk);
        iack = 1;
        @(negedge clk);
        iack = 0;
        push_now(SEL_VEC, exp_vec, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk_rd(6'h08, 8'h00, "R1 status src0 after reset");
        chk_rd(6'h00, 8'h00, "R1 master after reset");
        chk_sig(SEL_REQ, 1'b0, "R1 int_req after reset");
        chk_sig(SEL_IEO, 1'b1, "R1 ieo follows iei");
        chk_rd(6'h1F, 8'hFF, "R1 current vector none");

        for (int i = 0; i < 5; i++) wr(6'(6'h10 + i), 8'(8'h40 + i * 16));
        chk_rd(6'h12, 8'h60, "R3 vector register readback");

        // R2 set enable with junk low bits; R3 layout
        wr(6'h09, 8'hC5);
        chk_rd(6'h09, 8'h40, "R2 set enable, low bits ignored");
        wr(6'h09, 8'h80);
        chk_rd(6'h09, 8'h60, "R3 enable+pending layout");
        chk_sig(SEL_REQ, 1'b0, "R4 no request with master enable off");
        chk_rd(6'h1F, 8'hFF, "R7 no winner while masked");

        wr(6'h00, 8'h80);
        chk_sig(SEL_REQ, 1'b1, "R4 request with master enable");
        chk_rd(6'h1F, 8'h50, "R7 current vector src1");
        chk_sig(SEL_IEO, 1'b0, "R8 ieo low while requesting");

        // R5 error flag
        evt(5'b00010);
        chk_rd(6'h09, 8'h70, "R5 error on repeated event");
        wr(6'h09, 8'hA0);
        chk_rd(6'h09, 8'h40, "R5 clear pending clears error");
        chk_sig(SEL_REQ, 1'b0, "R4 request drops after clear");

        // R2 null command
        wr(6'h0A, 8'hC0);
        wr(6'h0A, 8'h1F);
        chk_rd(6'h0A, 8'h40, "R2 null command no change");

        // R6 priority and R9 acknowledge
        wr(6'h08, 8'hC0);
        wr(6'h0B, 8'hC0);
        evt(5'b01001);
        chk_rd(6'h1F, 8'h40, "R6 src0 wins over src3");
        ack(9'h140, "R9 ack vector src0");
        chk_rd(6'h08, 8'hE0, "R9 under-service set on winner");
        chk_sig(SEL_REQ, 1'b0, "R6 lower source blocked by service");
        chk_sig(SEL_IEO, 1'b0, "R8 ieo low under service");
        wr(6'h08, 8'h60);
        chk_rd(6'h08, 8'h60, "R2 clear under-service");
        wr(6'h08, 8'h20);
        chk_rd(6'h08, 8'h40, "R2 clear pending and service");
        chk_rd(6'h1F, 8'h70, "R7 current vector src3");

        // R9 status in vector for counter group
        wr(6'h00, 8'h84);
        chk_rd(6'h1F, 8'h76, "R9 merged current vector");
        ack(9'h176, "R9 merged ack vector src3");
        chk_rd(6'h0B, 8'hE0, "R9 src3 under service");

        // R6 lower blocked, higher not
        wr(6'h0C, 8'hC0);
        evt(5'b10000);
        chk_sig(SEL_REQ, 1'b0, "R6 src4 blocked by src3 service");
        chk_rd(6'h0C, 8'h60, "R6 src4 pending recorded");
        evt(5'b00010);
        chk_sig(SEL_REQ, 1'b1, "R6 src1 not blocked");
        chk_rd(6'h1F, 8'h50, "R7 src1 vector unmerged");

        // R11 ack with chain input low
        @(negedge clk) iei = 0;
        chk_sig(SEL_IEO, 1'b0, "R8 ieo low with iei low");
        ack(9'h000, "R11 no grant with iei low");
        chk_rd(6'h09, 8'h60, "R11 no service set with iei low");
        @(negedge clk) iei = 1;

        // R10 no vector
        wr(6'h00, 8'hA0);
        ack(9'h000, "R10 vector suppressed");
        chk_rd(6'h09, 8'hE0, "R10 service still set");

        // R11 ack with no request
        ack(9'h000, "R11 no grant without request");

        // R12 software reset
        wr(6'h00, 8'h01);
        chk_rd(6'h00, 8'h00, "R12 master cleared");
        chk_rd(6'h0B, 8'h00, "R12 src3 flags cleared");
        chk_rd(6'h09, 8'h00, "R12 src1 flags cleared");
        chk_sig(SEL_REQ, 1'b0, "R12 request low");
        chk_sig(SEL_IEO, 1'b1, "R12 ieo restored");
        chk_rd(6'h13, 8'h70, "R12 vector kept");

        // R8 disable lower chain
        wr(6'h00, 8'h40);
        chk_sig(SEL_IEO, 1'b0, "R8 chain disabled");
        chk_rd(6'h00, 8'h40, "R8 master readback");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule